// File: doc/BRIEF.md
# Preset Store Sequencer for a Dual-Channel Digital Potentiometer

This block owns the small nonvolatile byte store that sits behind a two-channel digital potentiometer. The store holds one preset per wiper channel plus spare constant bytes for the user. The block also holds the live wiper registers. A command decoder hands it one decoded request at a time: load a wiper, save to the store, restore the wipers from the store, or read a store byte or a wiper. Every slow operation runs for a cycle count set by a parameter. During that time an active-low ready flag is held low and a lock output freezes the serial input register upstream.

Two inputs act on the block directly. An active-low write-protect input blocks wiper loads and saves. An active-low preset pin works in two phases: while it is held low, the wipers sit at midscale; when it rises, the wipers reload from their stored presets. Reset stands for power-on. It puts factory contents in the store and starts an automatic restore window.

Only one timed operation can run at a time. A request that arrives while the block is busy is discarded, and a sticky flag records that this happened.

Top module: `preset_store_seq`

## Requirements
- R1: Reset loads both preset locations (addresses 0 and 1) with midscale 0x80, loads user locations 2..15 with 0x00 and sets both wipers to 0x80. After reset is released, rdy_n stays low for exactly RESTORE_CYC cycles while the wipers reload from their presets.
- R2: Op code 1 (load wiper) with addr below 2 copies the data field into that wiper on the next cycle and never drives rdy_n low. With addr 2 or above it changes nothing.
- R3: Op code 2 (save) holds rdy_n low for exactly SAVE_CYC cycles and then writes the store. Address 0 or 1 receives that channel's present wiper value. Any other address receives the data field.
- R4: Op code 3 (restore) holds rdy_n low for exactly RESTORE_CYC cycles and then loads every wiper from its preset location.
- R5: Op code 4 (read store byte) and op code 5 (read wiper) each hold rdy_n low for exactly READ_CYC cycles. rd_valid then pulses for one cycle, in the cycle rdy_n returns high, with the store byte or the wiper value on rd_data. Op code 5 with addr 2 or above returns 0x00.
- R6: lock is high exactly while rdy_n is low.
- R7: A request with op code 1..5 that arrives while the block is busy or while the preset pin is low has no effect. It sets drop, and drop stays set until reset.
- R8: While wp_n is low, op codes 1 and 2 are ignored and start no busy window. Restore and the preset pin still refresh the wipers.
- R9: While preset_n is low, both wipers read 0x80 from the next cycle and rdy_n is low. Any operation in flight is abandoned without its effect.
- R10: On the cycle after preset_n rises, the wipers hold their stored presets and rdy_n stays low for exactly PRESET_CYC cycles.
- R11: Op codes 0, 6 and 7 change nothing, start no busy window and never set drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-on |
| req_valid | input | 1 | Decoded request present this cycle |
| req_op | input | 3 | Op code: 0 none, 1 load wiper, 2 save, 3 restore, 4 read store, 5 read wiper |
| req_addr | input | AW (4) | Store location or wiper channel |
| req_data | input | DW (8) | Data field |
| wp_n | input | 1 | Active-low write protect |
| preset_n | input | 1 | Active-low preset pin |
| wiper_o | output | NCH*DW (16) | Wiper registers, channel 0 in the low byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DW (8) | Read result |
| rdy_n | output | 1 | Active-low ready: low while an operation is busy |
| lock | output | 1 | Freezes the upstream serial input register |
| drop | output | 1 | Sticky: a request was discarded |

## Verification
The bench counts the busy cycles of every timed op code and of the power-on and preset windows. A design that decremented off by one, or that shared one duration across all ops, would show a different count. It sends a load-wiper request in the middle of a save. The wiper must keep its value and drop must latch, which catches a design that accepts work while busy. It pulls the preset pin low during a save. A design that does not abandon the save would show the new value when the location is read back. With write protect low, a protected save is followed by a readback of its target. This shows the store byte was not written, as it would be in a design that checked protection only for wiper loads.

// File: rtl/preset_store_seq.sv
module preset_store_seq #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int NCH         = 2,
  parameter int SAVE_CYC    = 24,
  parameter int RESTORE_CYC = 6,
  parameter int READ_CYC    = 3,
  parameter int PRESET_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              wp_n,
  input  logic              preset_n,
  output logic [NCH*DW-1:0] wiper_o,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              rdy_n,
  output logic              lock,
  output logic              drop
);

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NLOC = 1 << AW;
  localparam int MAXD = maxi(maxi(SAVE_CYC, RESTORE_CYC), maxi(READ_CYC, PRESET_CYC));
  localparam int CW   = $clog2(MAXD + 1);
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [DW-1:0] MID   = DW'(1 << (DW - 1));
  localparam logic [AW-1:0] NCH_A = AW'(NCH);

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_SAVE = 3'd2;
  localparam logic [2:0] OP_RST  = 3'd3;
  localparam logic [2:0] OP_RDNV = 3'd4;
  localparam logic [2:0] OP_RDW  = 3'd5;

  logic [DW-1:0] nv    [NLOC];
  logic [DW-1:0] wiper [NCH];
  logic [CW-1:0] cnt;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          pl_q;
  logic          drop_q;
  logic          rdv_q;
  logic [DW-1:0] rdd_q;

  logic busy, act_req, wp_block, rise, ch_ok_req, ch_ok_q;
  logic [DW-1:0] wip_sel;

  assign busy      = (cnt != '0) || pl_q;
  assign act_req   = req_valid && (req_op >= OP_WR) && (req_op <= OP_RDW);
  assign wp_block  = !wp_n && ((req_op == OP_WR) || (req_op == OP_SAVE));
  assign rise      = pl_q && preset_n;
  assign ch_ok_req = req_addr < NCH_A;
  assign ch_ok_q   = addr_q < NCH_A;
  assign wip_sel   = ch_ok_q ? wiper[addr_q[CHW-1:0]] : '0;

  assign rdy_n    = !busy;
  assign lock     = busy;
  assign drop     = drop_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign wiper_o[g*DW +: DW] = wiper[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOC; i++) nv[i] <= (i < NCH) ? MID : '0;
      for (int c = 0; c < NCH; c++) wiper[c] <= MID;
      cnt    <= CW'(RESTORE_CYC);
      op_q   <= OP_RST;
      addr_q <= '0;
      data_q <= '0;
      pl_q   <= 1'b0;
      drop_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
    end else begin
      rdv_q <= 1'b0;
      pl_q  <= !preset_n;
      if (!preset_n) begin
        cnt  <= '0;
        op_q <= OP_NOP;
        for (int c = 0; c < NCH; c++) wiper[c] <= MID;
        if (act_req) drop_q <= 1'b1;
      end else if (rise) begin
        for (int c = 0; c < NCH; c++) wiper[c] <= nv[c];
        cnt  <= CW'(PRESET_CYC);
        op_q <= OP_NOP;
        if (act_req) drop_q <= 1'b1;
      end else if (cnt != '0) begin
        if (act_req) drop_q <= 1'b1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          case (op_q)
            OP_SAVE: nv[addr_q] <= ch_ok_q ? wiper[addr_q[CHW-1:0]] : data_q;
            OP_RST:  for (int c = 0; c < NCH; c++) wiper[c] <= nv[c];
            OP_RDNV: begin rdv_q <= 1'b1; rdd_q <= nv[addr_q]; end
            OP_RDW:  begin rdv_q <= 1'b1; rdd_q <= wip_sel; end
            default: ;
          endcase
        end
      end else if (act_req && !wp_block) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        case (req_op)
          OP_WR:   if (ch_ok_req) wiper[req_addr[CHW-1:0]] <= req_data;
          OP_SAVE: cnt <= CW'(SAVE_CYC);
          OP_RST:  cnt <= CW'(RESTORE_CYC);
          default: cnt <= CW'(READ_CYC);
        endcase
      end
    end
  end

  AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> (wiper_o == {NCH{MID}}));  // R9

  AST_READ_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rdy_n && $past(!rdy_n)));  // R5

  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && req_valid && req_op == OP_WR && preset_n && !busy) |=> $stable(wiper_o));  // R8

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> drop);  // R7

  AST_DROP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_req) |=> drop);  // R7

  AST_LOCK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> lock);  // R6

endmodule

// File: tb/preset_store_seq_tb.sv
module preset_store_seq_tb;
  localparam int SAVE_C = 24, REST_C = 6, READ_C = 3, PRE_C = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, wp_n = 1'b1, preset_n = 1'b1;
  logic [2:0] req_op = '0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic [15:0] wiper_o;
  logic rd_valid, rdy_n, lock, drop;
  logic [7:0] rd_data;

  preset_store_seq #(.DW(8), .AW(4), .NCH(2), .SAVE_CYC(SAVE_C), .RESTORE_CYC(REST_C),
                     .READ_CYC(READ_C), .PRESET_CYC(PRE_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .wp_n(wp_n), .preset_n(preset_n), .wiper_o(wiper_o),
    .rd_valid(rd_valid), .rd_data(rd_data), .rdy_n(rdy_n), .lock(lock), .drop(drop));

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] expq[$];
  logic [7:0] exp_nv[16];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] wip(int c);
    return wiper_o[c*8 +: 8];
  endfunction

  task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d, output int n);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rdy_n && n < 1000) begin
      chk(lock == 1'b1, "R6 lock while busy", lock, 1);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_nv(input logic [3:0] a, input string tag);
    int n;
    expq.push_back(exp_nv[a]);
    issue(3'd4, a, 8'h00, n);
    chk(n == READ_C, tag, n, READ_C);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected read", rd_data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R5 read data", rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) exp_nv[i] = (i < 2) ? 8'h80 : 8'h00;
    repeat (3) @(negedge clk);
    chk(wiper_o == 16'h8080, "R1 reset wipers", wiper_o, 16'h8080);
    chk(rdy_n == 1'b0 && lock == 1'b1, "R6 busy in reset", {rdy_n, lock}, 2'b01);
    chk(drop == 1'b0, "R7 drop clear at reset", drop, 0);
    rst_n = 1'b1;
    n = 0;
    while (!rdy_n && n < 1000) begin n++; @(negedge clk); end
    chk(n == REST_C, "R1 power-on restore window", n, REST_C);
    chk(wiper_o == 16'h8080, "R1 wipers after power-on", wiper_o, 16'h8080);

    for (int i = 0; i < 16; i++) rd_nv(4'(i), "R1 R5 store default read");
    expq.push_back(8'h80); issue(3'd5, 4'd0, 8'h00, n);
    chk(n == READ_C, "R5 wiper read busy", n, READ_C);
    expq.push_back(8'h00); issue(3'd5, 4'd9, 8'h00, n);

    issue(3'd1, 4'd0, 8'h33, n);
    chk(n == 0, "R2 load no busy", n, 0);
    chk(wip(0) == 8'h33, "R2 load ch0", wip(0), 8'h33);
    issue(3'd1, 4'd1, 8'hC5, n);
    chk(wip(1) == 8'hC5, "R2 load ch1", wip(1), 8'hC5);
    issue(3'd1, 4'd5, 8'h11, n);
    chk(wiper_o == 16'hC533, "R2 bad channel ignored", wiper_o, 16'hC533);

    for (int op = 0; op < 8; op = (op == 0) ? 6 : op + 1) begin
      issue(3'(op), 4'd0, 8'hAA, n);
      chk(n == 0 && wiper_o == 16'hC533 && drop == 1'b0, "R11 null op", {n[7:0], wiper_o}, 24'h00C533);
    end

    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 4'd0; req_data = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rdy_n && n < 1000) begin
      if (n == 4) begin req_valid = 1'b1; req_op = 3'd1; req_addr = 4'd0; req_data = 8'h77; end
      else req_valid = 1'b0;
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(n == SAVE_C, "R3 save window", n, SAVE_C);
    chk(wip(0) == 8'h33, "R7 load during save dropped", wip(0), 8'h33);
    chk(drop == 1'b1, "R7 drop set", drop, 1);
    exp_nv[0] = 8'h33;
    issue(3'd2, 4'd7, 8'h5A, n); exp_nv[7] = 8'h5A;
    chk(n == SAVE_C, "R3 user save window", n, SAVE_C);
    issue(3'd2, 4'd1, 8'h00, n); exp_nv[1] = 8'hC5;
    rd_nv(4'd0, "R3 readback ch0"); rd_nv(4'd1, "R3 readback ch1"); rd_nv(4'd7, "R3 readback user");

    issue(3'd1, 4'd0, 8'h01, n); issue(3'd1, 4'd1, 8'h02, n);
    issue(3'd3, 4'd0, 8'h00, n);
    chk(n == REST_C, "R4 restore window", n, REST_C);
    chk(wiper_o == 16'hC533, "R4 restore wipers", wiper_o, 16'hC533);

    wp_n = 1'b0;
    issue(3'd1, 4'd0, 8'hEE, n);
    chk(n == 0 && wip(0) == 8'h33, "R8 protected load", wip(0), 8'h33);
    issue(3'd2, 4'd3, 8'h99, n);
    chk(n == 0, "R8 protected save no busy", n, 0);
    issue(3'd3, 4'd0, 8'h00, n);
    chk(n == REST_C, "R8 restore under protect", n, REST_C);
    wp_n = 1'b1;
    rd_nv(4'd3, "R8 protected save not stored");

    issue(3'd1, 4'd0, 8'h10, n);
    @(negedge clk); preset_n = 1'b0;
    @(negedge clk);
    chk(wiper_o == 16'h8080, "R9 preset low midscale", wiper_o, 16'h8080);
    chk(rdy_n == 1'b0 && lock == 1'b1, "R9 busy while preset low", {rdy_n, lock}, 2'b01);
    repeat (3) @(negedge clk);
    preset_n = 1'b1;
    @(negedge clk);
    chk(wiper_o == 16'hC533, "R10 reload on rise", wiper_o, 16'hC533);
    n = 0;
    while (!rdy_n && n < 1000) begin n++; @(negedge clk); end
    chk(n == PRE_C, "R10 preset window", n, PRE_C);

    issue(3'd1, 4'd0, 8'h44, n);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    preset_n = 1'b0;
    repeat (2) @(negedge clk);
    preset_n = 1'b1;
    @(negedge clk);
    n = 0;
    while (!rdy_n && n < 1000) begin n++; @(negedge clk); end
    chk(wip(0) == 8'h33, "R10 reload after abort", wip(0), 8'h33);
    repeat (SAVE_C) @(negedge clk);
    rd_nv(4'd0, "R9 aborted save not stored");
    chk(drop == 1'b1, "R7 drop sticky", drop, 1);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
    finish_run();
  end
endmodule